// File: doc/BRIEF.md
# Two-VC Priority Packet Output Arbiter

This block serves one output port of a five-port router. Up to four input controllers offer flits to it on two virtual channels, VC0 and VC1. Inside each VC the block picks one packet at a time and holds that choice until the packet's final flit has gone out. Across the VCs, each link slot goes to VC0 first. The shared link carries the chosen flit, which is registered and tagged with its VC.

Each flit is `FLIT_W` bits wide. A new packet is marked by a begin bit, and only a flit with that bit set can open arbitration for its input on its VC. The flit carrying the end bit releases the hold. An input learns in the same cycle that its flit was taken, through a combinational pop strobe. On VC1 the input also gets an accept token back one cycle later. After every VC1 flit the link keeps a gap so that a VC0 flit can follow.

Top module: `parb_out_arbiter`

## Requirements
- R1: While `rst_n` is low, `link_vld` and `vc1_token` are all zero.
- R2: When VC0 has an eligible flit (the owner's flit in an open VC0 packet, or a begin-marked flit if no VC0 packet is open), VC0 takes the link slot and no VC1 pop occurs in that cycle.
- R3: VC1 cannot send in the cycle that immediately follows a VC1 flit being taken, so no two back-to-back link cycles carry `link_vc` = 1.
- R4: If no packet is open on a VC, an input's flit on that VC is popped only when its begin bit (bit `FLIT_W-1`) is set. Body flits presented while the VC is free are never taken.
- R5: Once a VC grants an input, that VC takes flits from no other input until a flit with the end bit (bit `FLIT_W-2`) is taken. A flit with both bits set is a one-flit packet and releases the VC at once.
- R6: A new grant on a VC searches inputs in ascending index order, wrapping around, and starts just after the input that received the last new grant on that VC. After reset the search starts at input 0.
- R7: A flit popped in cycle t appears on `link_flit` in cycle t+1, unchanged, with `link_vld` = 1 and `link_vc` equal to its VC (0 or 1).
- R8: When input i's VC1 flit is popped in cycle t, `vc1_token` in cycle t+1 is one-hot on bit i. In all other cycles it is zero.
- R9: While a VC1 packet is still open, VC0 packets may take link slots between its flits.
- R10: Across both VCs, at most one pop strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vc0_vld | input | N | Input i is offering a VC0 flit |
| vc0_flit | input | N*FLIT_W | VC0 flits, input i in slice i |
| vc0_pop | output | N | VC0 flit of input i taken this cycle |
| vc1_vld | input | N | Input i is offering a VC1 flit |
| vc1_flit | input | N*FLIT_W | VC1 flits, input i in slice i |
| vc1_pop | output | N | VC1 flit of input i taken this cycle |
| link_vld | output | 1 | Link carries a flit |
| link_vc | output | 1 | VC of the link flit |
| link_flit | output | FLIT_W | Flit on the link |
| vc1_token | output | N | One-cycle VC1 accept token per input |

## Verification
The bench drives several patterns: all four inputs contending at once on VC0, two VC1 packets that compete for back-to-back slots, a long VC1 packet with VC0 packets arriving in the middle of it, and an orphan body flit offered while the VC is free. A design that ignores the VC1 gap would put VC1 flits on consecutive cycles. A design that does not honour the hold would interleave two VC0 packets. A design that treats any valid flit as a request would pop the orphan body flit. Single-flit packets and a pseudo-random mix exercise round-robin wrap-around and release on a flit that is both first and last. A wrong pointer update would show up there as a different grant order.

// File: rtl/parb_pkg.sv
package parb_pkg;
  typedef enum logic {VC_FAST = 1'b0, VC_BULK = 1'b1} vc_e;

  // index of the input visited k steps after 'from' in a ring of n inputs
  function automatic int ring_step(int from, int k, int n);
    return (from + k) % n;
  endfunction
endpackage

// File: rtl/parb_vc_arb.sv
module parb_vc_arb #(
  parameter int N = 4,
  parameter int FLIT_W = 34,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      vld,
  input  logic [N*FLIT_W-1:0] flits,
  input  logic              allow,
  output logic              cand,
  output logic [IW-1:0]     cand_idx,
  output logic [FLIT_W-1:0] cand_flit,
  output logic [N-1:0]      pop
);
  import parb_pkg::*;

  logic          locked;
  logic [IW-1:0] owner;
  logic [IW-1:0] last;
  logic [N-1:0]  heads;
  logic [IW:0]   pick;
  logic          fire;
  logic          tail;

  // an input may open a packet only with a begin-marked flit
  for (genvar i = 0; i < N; i++) begin : g_head
    assign heads[i] = vld[i] & flits[i*FLIT_W + FLIT_W - 1];
  end

  // returns {found, index}; nearest requester after 'from' wins
  function automatic logic [IW:0] rr_pick(logic [N-1:0] req, logic [IW-1:0] from);
    logic [IW:0] r;
    r = '0;
    for (int k = N; k >= 1; k--) begin
      int j;
      j = ring_step(int'(from), k, N);
      if (req[j]) r = {1'b1, IW'(j)};
    end
    return r;
  endfunction

  always_comb begin
    pick = rr_pick(heads, last);
    if (locked) begin
      cand     = vld[owner];
      cand_idx = owner;
    end else begin
      cand     = pick[IW];
      cand_idx = pick[IW-1:0];
    end
    cand_flit = flits[int'(cand_idx)*FLIT_W +: FLIT_W];
  end

  assign fire = cand & allow;
  assign tail = cand_flit[FLIT_W-2];
  assign pop  = fire ? (N'(1) << cand_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      last   <= IW'(N-1);
    end else if (fire) begin
      if (!locked) last <= cand_idx;
      owner  <= cand_idx;
      locked <= !tail;
    end
  end
endmodule

// File: rtl/parb_link.sv
module parb_link #(
  parameter int N = 4,
  parameter int FLIT_W = 34,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand0,
  input  logic              cand1,
  input  logic [IW-1:0]     idx1,
  input  logic [FLIT_W-1:0] flit0,
  input  logic [FLIT_W-1:0] flit1,
  output logic              allow1,
  output logic              link_vld,
  output logic              link_vc,
  output logic [FLIT_W-1:0] link_flit,
  output logic [N-1:0]      tok1
);
  import parb_pkg::*;

  logic prev1;
  logic take1;

  // VC1 waits for VC0 and never uses two slots in a row
  assign allow1 = !cand0 && !prev1;
  assign take1  = cand1 && allow1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_vld  <= 1'b0;
      link_vc   <= VC_FAST;
      link_flit <= '0;
      tok1      <= '0;
      prev1     <= 1'b0;
    end else begin
      link_vld  <= cand0 | take1;
      link_vc   <= cand0 ? VC_FAST : VC_BULK;
      link_flit <= cand0 ? flit0 : flit1;
      tok1      <= take1 ? (N'(1) << idx1) : '0;
      prev1     <= take1;
    end
  end
endmodule

// File: rtl/parb_out_arbiter.sv
module parb_out_arbiter #(
  parameter int N = 4,
  parameter int FLIT_W = 34,
  localparam int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        vc0_vld,
  input  logic [N*FLIT_W-1:0] vc0_flit,
  output logic [N-1:0]        vc0_pop,
  input  logic [N-1:0]        vc1_vld,
  input  logic [N*FLIT_W-1:0] vc1_flit,
  output logic [N-1:0]        vc1_pop,
  output logic                link_vld,
  output logic                link_vc,
  output logic [FLIT_W-1:0]   link_flit,
  output logic [N-1:0]        vc1_token
);
  logic [1:0][N-1:0]        vld_a;
  logic [1:0][N*FLIT_W-1:0] flit_a;
  logic [1:0]               allow_a;
  logic [1:0]               cand_a;
  logic [1:0][IW-1:0]       idx_a;
  logic [1:0][FLIT_W-1:0]   cflit_a;
  logic [1:0][N-1:0]        pop_a;
  logic                     vc0_cand;
  logic                     vc1_allow;

  assign vld_a[0]   = vc0_vld;
  assign vld_a[1]   = vc1_vld;
  assign flit_a[0]  = vc0_flit;
  assign flit_a[1]  = vc1_flit;
  assign allow_a[0] = 1'b1;
  assign allow_a[1] = vc1_allow;
  assign vc0_pop    = pop_a[0];
  assign vc1_pop    = pop_a[1];
  assign vc0_cand   = cand_a[0];

  for (genvar v = 0; v < 2; v++) begin : g_vc
    parb_vc_arb #(.N(N), .FLIT_W(FLIT_W)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .vld(vld_a[v]), .flits(flit_a[v]), .allow(allow_a[v]),
      .cand(cand_a[v]), .cand_idx(idx_a[v]), .cand_flit(cflit_a[v]),
      .pop(pop_a[v])
    );
  end

  parb_link #(.N(N), .FLIT_W(FLIT_W)) u_link (
    .clk(clk), .rst_n(rst_n),
    .cand0(cand_a[0]), .cand1(cand_a[1]), .idx1(idx_a[1]),
    .flit0(cflit_a[0]), .flit1(cflit_a[1]),
    .allow1(vc1_allow),
    .link_vld(link_vld), .link_vc(link_vc), .link_flit(link_flit),
    .tok1(vc1_token)
  );
endmodule

// File: rtl/parb_out_arbiter_chk.sv
module parb_out_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] vc0_pop,
  input logic [N-1:0] vc1_pop,
  input logic         vc0_cand,
  input logic         link_vld,
  input logic         link_vc,
  input logic [N-1:0] vc1_token
);
  p_single_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({vc0_pop, vc1_pop}) <= 1);

  p_vc0_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vc0_cand |-> (vc1_pop == '0));

  p_pop_to_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|{vc0_pop, vc1_pop}) |=> link_vld);

  p_vc1_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_vld && link_vc) |=> !(link_vld && link_vc));

  p_token_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|vc1_pop) |=> (vc1_token == $past(vc1_pop)));

  p_token_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vc1_token));
endmodule

bind parb_out_arbiter parb_out_arbiter_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .vc0_pop(vc0_pop), .vc1_pop(vc1_pop), .vc0_cand(vc0_cand),
  .link_vld(link_vld), .link_vc(link_vc), .vc1_token(vc1_token)
);

// File: tb/parb_out_arbiter_tb.sv
`timescale 1ns/1ps
module parb_out_arbiter_tb;
  localparam int N = 4;
  localparam int FW = 34;
  localparam int WD = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    vc0_vld = '0, vc1_vld = '0;
  logic [N*FW-1:0] vc0_flit = '0, vc1_flit = '0;
  logic [N-1:0]    vc0_pop, vc1_pop, vc1_token;
  logic            link_vld, link_vc;
  logic [FW-1:0]   link_flit;

  always #10 clk = ~clk;

  parb_out_arbiter #(.N(N), .FLIT_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .vc0_vld(vc0_vld), .vc0_flit(vc0_flit), .vc0_pop(vc0_pop),
    .vc1_vld(vc1_vld), .vc1_flit(vc1_flit), .vc1_pop(vc1_pop),
    .link_vld(link_vld), .link_vc(link_vc), .link_flit(link_flit),
    .vc1_token(vc1_token)
  );

  logic [FW-1:0] q [2][N][$];
  int own [2];
  int last [2];
  bit prev1;
  bit saw_il;
  logic e_vld, e_vc;
  logic [FW-1:0] e_flit;
  logic [N-1:0] e_tok;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic add_pkt(input int vc, input int inp, input int len, input int tag);
    for (int k = 0; k < len; k++) begin
      logic [FW-1:0] f;
      f = {k == 0, k == len - 1, (FW-2)'(tag * 256 + k)};
      q[vc][inp].push_back(f);
    end
  endtask

  task automatic drive();
    logic [N-1:0] v0, v1;
    logic [N*FW-1:0] f0, f1;
    v0 = '0; v1 = '0; f0 = '0; f1 = '0;
    for (int i = 0; i < N; i++) begin
      if (q[0][i].size() > 0) begin v0[i] = 1'b1; f0[i*FW +: FW] = q[0][i][0]; end
      if (q[1][i].size() > 0) begin v1[i] = 1'b1; f1[i*FW +: FW] = q[1][i][0]; end
    end
    vc0_vld = v0; vc1_vld = v1; vc0_flit = f0; vc1_flit = f1;
  endtask

  task automatic model();
    int cand [2];
    int sv;
    logic [N-1:0] ep0, ep1;
    logic [FW-1:0] f;
    for (int v = 0; v < 2; v++) begin
      cand[v] = -1;
      if (own[v] >= 0) begin
        if (q[v][own[v]].size() > 0) cand[v] = own[v];
      end else begin
        for (int k = 1; k <= N; k++) begin
          int i;
          i = (last[v] + k) % N;
          if (cand[v] < 0 && q[v][i].size() > 0 && q[v][i][0][FW-1]) cand[v] = i;
        end
      end
    end
    sv = -1;
    if (cand[0] >= 0) sv = 0;
    else if (cand[1] >= 0 && !prev1) sv = 1;
    ep0 = '0; ep1 = '0;
    if (sv == 0) ep0[cand[0]] = 1'b1;
    if (sv == 1) ep1[cand[1]] = 1'b1;
    chk(vc0_pop == ep0, "R6 R5 R4 vc0_pop", 64'(vc0_pop), 64'(ep0));
    chk(vc1_pop == ep1, "R2 R3 R10 vc1_pop", 64'(vc1_pop), 64'(ep1));
    if (sv == 0 && own[1] >= 0) saw_il = 1'b1;
    e_vld = (sv >= 0);
    e_tok = '0;
    prev1 = (sv == 1);
    if (sv >= 0) begin
      int i;
      i = cand[sv];
      f = q[sv][i].pop_front();
      e_vc = sv[0];
      e_flit = f;
      if (own[sv] < 0) last[sv] = i;
      own[sv] = f[FW-2] ? -1 : i;
      if (sv == 1) e_tok[i] = 1'b1;
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > WD) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
      finish_run();
    end
    chk(link_vld == e_vld, "R7 link_vld", 64'(link_vld), 64'(e_vld));
    if (e_vld) begin
      chk(link_vc == e_vc, "R2 link_vc", 64'(link_vc), 64'(e_vc));
      chk(link_flit == e_flit, "R7 link_flit", 64'(link_flit), 64'(e_flit));
    end
    chk(vc1_token == e_tok, "R8 vc1_token", 64'(vc1_token), 64'(e_tok));
    drive();
    #1;
    model();
  endtask

  function automatic bit all_empty();
    for (int v = 0; v < 2; v++)
      for (int i = 0; i < N; i++)
        if (q[v][i].size() > 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic drain();
    while (!all_empty()) step();
    repeat (3) step();
  endtask

  initial begin
    own[0] = -1; own[1] = -1; last[0] = N - 1; last[1] = N - 1;
    prev1 = 1'b0; saw_il = 1'b0;
    e_vld = 1'b0; e_vc = 1'b0; e_flit = '0; e_tok = '0;
    repeat (3) @(negedge clk);
    chk(link_vld == 1'b0, "R1 reset link_vld", 64'(link_vld), 64'd0);
    chk(vc1_token == '0, "R1 reset vc1_token", 64'(vc1_token), 64'd0);
    rst_n = 1'b1;

    // A: four VC0 packets contending, round robin and hold (R5, R6)
    for (int i = 0; i < N; i++) add_pkt(0, i, 2, 16 + i);
    drain();

    // B: two VC1 packets, gap after every VC1 flit (R3, R8)
    add_pkt(1, 1, 3, 32);
    add_pkt(1, 3, 3, 33);
    drain();

    // C: long VC1 packet with VC0 packets arriving mid-way (R9, R2)
    add_pkt(1, 2, 6, 48);
    step(); step();
    add_pkt(0, 1, 2, 49);
    add_pkt(0, 0, 1, 50);
    drain();
    chk(saw_il, "R9 vc0 between vc1 flits", 64'(saw_il), 64'd1);

    // D: orphan body flit while VC0 is free is never taken (R4)
    q[0][3].push_back({1'b0, 1'b0, (FW-2)'(99)});
    for (int k = 0; k < 5; k++) begin
      step();
      chk(vc0_pop[3] == 1'b0, "R4 orphan body pop", 64'(vc0_pop[3]), 64'd0);
      chk(link_vld == 1'b0, "R4 link idle", 64'(link_vld), 64'd0);
    end
    q[0][3].delete();
    drain();

    // E: one-flit packets release at once, wrap of the pointer (R5, R6)
    for (int r = 0; r < 3; r++)
      for (int i = N - 1; i >= 0; i--) add_pkt(r % 2, i, 1, 64 + r * N + i);
    drain();

    // F: pseudo-random mix over both VCs
    for (int it = 0; it < 300; it++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:6] == 2'b00)
        add_pkt(int'(lfsr[0]), int'(lfsr[2:1]), 1 + int'(lfsr[4:3]), it);
      step();
    end
    drain();

    finish_run();
  end
endmodule